// File: doc/BRIEF.md
# Interrupt Request Sense Latch

This block builds the eight-bit pending-request vector of a classic vectored interrupt controller from raw request wires. Each line owns a sense latch that catches rising transitions when the line is edge-triggered. A per-line selector switches the line to level triggering, where the request simply tracks the wire. Level-triggered lines may also be driven by several sources at once through a per-line assertion counter, so the line keeps requesting until the last source lets go.

The latch works together with the in-service bits kept elsewhere in the controller. While a line is in service, or during the initialization clear, its latch stops catching edges and copies the wire instead. An acknowledge empties the line's latch and raises a freeze. While frozen, the pending vector holds still, and any line that sees activity reads as not pending. Releasing the freeze recomputes every line. Priority resolution, masking and end-of-interrupt handling sit in neighbouring blocks.

Top module: `irq_req_latch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pending vector `irr_o` is all zeros.
- R2: An edge-triggered line (its `trig_level_i` bit 0) that rises while not frozen and not in service shows as pending in `irr_o` one clock later. It stays pending while the wire stays high.
- R3: An edge-triggered line that has been acknowledged and simply stays high does not become pending again. It needs a fall followed by a new rise.
- R4: A level-triggered line (`trig_level_i` bit 1) is pending exactly while it is requested and not frozen. After an acknowledge, it becomes pending again on freeze release if it is still requested.
- R5: While the `isr_i` bit of an edge-triggered line is 1, its latch copies the wire, so the pending bit follows the wire level without needing a rising edge. The latch value carries over once `isr_i` drops.
- R6: A `master_clr_i` cycle loads every latch with the current wire level and recomputes every pending bit. It also ends any freeze, so later activity is seen at once.
- R7: While frozen, a line with no activity in a cycle keeps its pending bit. A line with activity is forced to 0. Activity means a wire change, an acknowledge, or a source set or clear.
- R8: An acknowledge on line i (`ack_i` bit i) empties that line's latch and forces its pending bit to 0 one clock later. It also turns the freeze on.
- R9: `freeze_clr_i` ends the freeze and recomputes every line in the same clock. It wins over `freeze_set_i` and over the freeze raised by an acknowledge.
- R10: Each line has a 3-bit shared-source counter. `lvl_set_i` bit i increments it and `lvl_clr_i` bit i decrements it. Both at once leave it unchanged. It saturates at 7 and at 0, and the line is requested while the count is nonzero or `req_line_i` bit i is 1.
- R11: Bit i of every per-line vector belongs to line i. Lines do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_line_i | input | 8 | Raw request wire per line |
| lvl_set_i | input | 8 | Shared source asserts, per line (pulse) |
| lvl_clr_i | input | 8 | Shared source deasserts, per line (pulse) |
| trig_level_i | input | 8 | 1 = level-triggered, 0 = edge-triggered |
| isr_i | input | 8 | In-service bits from the controller |
| ack_i | input | 8 | Acknowledge of line i (one-hot pulse) |
| master_clr_i | input | 1 | Initialization clear pulse |
| freeze_set_i | input | 1 | Start freeze (poll in progress) |
| freeze_clr_i | input | 1 | End freeze |
| irr_o | output | 8 | Pending request vector |

## Verification
The bench holds an edge-triggered wire high across an acknowledge and freeze release. A design that treats the level as a new edge would re-raise the request there. It also drops and raises a wire while the line is in service, which shows whether the latch copies the wire or keeps catching edges. Freeze tests mix quiet and active lines, so a design that freezes everything, or nothing, shows a wrong bit. The shared counter is driven past 7 and below 0: a wrapping counter shows a spurious drop or a spurious request.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;

  localparam int unsigned LINES_DEF = 8;
  localparam int unsigned CNT_W_DEF = 3;

  typedef enum logic [1:0] {
    LATCH_HOLD,
    LATCH_FOLLOW,
    LATCH_DROP
  } latch_op_e;

  typedef struct packed {
    logic line;
    logic lvl_mode;
    logic in_svc;
    logic ack;
    logic mclr;
  } line_ctl_t;

endpackage

// File: rtl/irq_lvl_share_cnt.sv
module irq_lvl_share_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
    else if (dec_i && !inc_i && cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // request reflects this cycle's source events
  assign busy_o = (cnt_d != '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/irq_freeze_ctrl.sv
module irq_freeze_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ack_any_i,
  input  logic mclr_i,
  output logic frz_now_o,
  output logic freeze_q_o
);
  logic freeze_q;

  // clear and master clear win over any set
  assign frz_now_o = !mclr_i && !clr_i && (freeze_q || set_i || ack_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) freeze_q <= 1'b0;
    else         freeze_q <= frz_now_o;
  end

  assign freeze_q_o = freeze_q;
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_ctl_t ctl_i,
  input  logic      shared_busy_i,
  input  logic      src_evt_i,
  input  logic      frz_i,
  output logic      irr_o,
  output logic      edge_q_o
);
  logic      edge_q, latch_q, latch_d, irr_q, irr_d;
  logic      req, rise, upd, eval;
  latch_op_e op;

  assign req  = ctl_i.line | shared_busy_i;
  assign rise = ctl_i.line & ~edge_q;
  assign upd  = ctl_i.ack | src_evt_i | (ctl_i.line ^ edge_q);

  always_comb begin
    if (ctl_i.mclr)        op = LATCH_FOLLOW;
    else if (ctl_i.ack)    op = LATCH_DROP;
    else if (ctl_i.in_svc) op = LATCH_FOLLOW;
    else                   op = LATCH_HOLD;
  end

  always_comb begin
    unique case (op)
      LATCH_FOLLOW: latch_d = ctl_i.line;
      LATCH_DROP:   latch_d = 1'b0;
      default:      latch_d = latch_q | rise;
    endcase
  end

  assign eval = req & (ctl_i.lvl_mode | latch_d);

  always_comb begin
    if (frz_i) irr_d = upd ? 1'b0 : irr_q;
    else       irr_d = eval;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q  <= 1'b0;
      latch_q <= 1'b0;
      irr_q   <= 1'b0;
    end else begin
      edge_q  <= ctl_i.line;
      latch_q <= latch_d;
      irr_q   <= irr_d;
    end
  end

  assign irr_o    = irr_q;
  assign edge_q_o = edge_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_req_pkg::*;
#(
  parameter int unsigned N_LINES = LINES_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_line_i,
  input  logic [N_LINES-1:0] lvl_set_i,
  input  logic [N_LINES-1:0] lvl_clr_i,
  input  logic [N_LINES-1:0] trig_level_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [N_LINES-1:0] ack_i,
  input  logic               master_clr_i,
  input  logic               freeze_set_i,
  input  logic               freeze_clr_i,
  output logic [N_LINES-1:0] irr_o
);
  localparam int unsigned CNT_BITS = N_LINES * CNT_W;

  logic                frz_now, freeze_q;
  logic [N_LINES-1:0]  edge_q, busy;
  logic [CNT_BITS-1:0] cnt_flat;

  irq_freeze_ctrl u_frz (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (freeze_set_i),
    .clr_i      (freeze_clr_i),
    .ack_any_i  (|ack_i),
    .mclr_i     (master_clr_i),
    .frz_now_o  (frz_now),
    .freeze_q_o (freeze_q)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    line_ctl_t ctl;

    assign ctl.line     = req_line_i[i];
    assign ctl.lvl_mode = trig_level_i[i];
    assign ctl.in_svc   = isr_i[i];
    assign ctl.ack      = ack_i[i];
    assign ctl.mclr     = master_clr_i;

    irq_lvl_share_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (lvl_set_i[i]),
      .dec_i  (lvl_clr_i[i]),
      .cnt_o  (cnt_flat[i*CNT_W +: CNT_W]),
      .busy_o (busy[i])
    );

    irq_sense_cell u_cell (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .ctl_i         (ctl),
      .shared_busy_i (busy[i]),
      .src_evt_i     (lvl_set_i[i] | lvl_clr_i[i]),
      .frz_i         (frz_now),
      .irr_o         (irr_o[i]),
      .edge_q_o      (edge_q[i])
    );
  end
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned CNT_W   = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_LINES-1:0]         req_line_i,
  input logic [N_LINES-1:0]         lvl_set_i,
  input logic [N_LINES-1:0]         lvl_clr_i,
  input logic [N_LINES-1:0]         ack_i,
  input logic                       master_clr_i,
  input logic                       freeze_clr_i,
  input logic [N_LINES-1:0]         irr_o,
  input logic [N_LINES-1:0]         edge_q,
  input logic                       freeze_q,
  input logic [N_LINES*CNT_W-1:0]   cnt_flat
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R1
  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |=> irr_o == '0);

  // R6
  p_mclr_unfreeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_clr_i |=> !freeze_q);

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    logic [CNT_W-1:0] cnt;
    assign cnt = cnt_flat[i*CNT_W +: CNT_W];

    // R8
    p_ack_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[i] && !master_clr_i && !freeze_clr_i) |=> !irr_o[i] && freeze_q);

    // R7
    p_freeze_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (freeze_q && !freeze_clr_i && !master_clr_i && !ack_i[i] && !lvl_set_i[i]
       && !lvl_clr_i[i] && (req_line_i[i] == edge_q[i])) |=> $stable(irr_o[i]));

    // R2
    p_rise_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irr_o[i]) |-> $past(req_line_i[i] || lvl_set_i[i] || cnt != '0));

    // R10
    p_cnt_sat_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == CMAX && lvl_set_i[i] && !lvl_clr_i[i]) |=> cnt == CMAX);
    p_cnt_sat_lo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == '0 && lvl_clr_i[i] && !lvl_set_i[i]) |=> cnt == '0);
  end
endmodule

bind irq_req_latch irq_req_latch_chk #(.N_LINES(N_LINES), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_line_i   (req_line_i),
  .lvl_set_i    (lvl_set_i),
  .lvl_clr_i    (lvl_clr_i),
  .ack_i        (ack_i),
  .master_clr_i (master_clr_i),
  .freeze_clr_i (freeze_clr_i),
  .irr_o        (irr_o),
  .edge_q       (edge_q),
  .freeze_q     (freeze_q),
  .cnt_flat     (cnt_flat)
);

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_line, lset, lclr, isr, ack;
  logic [7:0] trig = 8'hF0;  // lines 4..7 level, 0..3 edge
  logic       mclr, fset, fclr;
  logic [7:0] irr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  irq_req_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_line_i(req_line), .lvl_set_i(lset),
    .lvl_clr_i(lclr), .trig_level_i(trig), .isr_i(isr), .ack_i(ack),
    .master_clr_i(mclr), .freeze_set_i(fset), .freeze_clr_i(fclr), .irr_o(irr)
  );

  task automatic step(input logic [7:0] l, input logic [7:0] s, input logic [7:0] c,
                      input logic [7:0] is, input logic [7:0] a, input logic mc,
                      input logic fs, input logic fc, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    req_line = l; lset = s; lclr = c; isr = is; ack = a;
    mclr = mc; fset = fs; fclr = fc;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: one result per driven cycle, sampled 2 ns after the edge
  always begin
    @(posedge clk);
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (irr !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irr_o=%02h expected %02h", it.tag, irr, it.exp);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_line = '0; lset = '0; lclr = '0; isr = '0; ack = '0;
    mclr = 1'b0; fset = 1'b0; fclr = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    n_chk++;
    if (irr !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 in reset: irr_o=%02h expected 00", irr);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R1 after reset");
    step(8'h01, 0, 0, 0, 0, 0, 0, 0, 8'h01, "R2 rise line0");
    step(8'h01, 0, 0, 0, 0, 0, 0, 0, 8'h01, "R2 held high");
    step(8'h01, 0, 0, 0, 8'h01, 0, 0, 0, 8'h00, "R8 ack line0");
    step(8'h03, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R7 active line forced 0");
    step(8'h03, 0, 0, 0, 0, 0, 0, 1, 8'h02, "R9/R3 release recompute");
    step(8'h02, 0, 0, 0, 0, 0, 0, 0, 8'h02, "R3 fall no request");
    step(8'h03, 0, 0, 0, 0, 0, 0, 0, 8'h03, "R3 new rise");
    step(8'h03, 0, 0, 0, 8'h02, 0, 0, 0, 8'h01, "R8/R7 ack line1, line0 holds");
    step(8'h03, 0, 0, 8'h02, 0, 0, 0, 1, 8'h03, "R5 in service follows");
    step(8'h01, 0, 0, 8'h02, 0, 0, 0, 0, 8'h01, "R5 fall in service");
    step(8'h03, 0, 0, 8'h02, 0, 0, 0, 0, 8'h03, "R5 rise in service");
    step(8'h03, 0, 0, 8'h00, 0, 0, 0, 0, 8'h03, "R5 latch kept");
    step(8'h03, 0, 0, 0, 0, 0, 1, 0, 8'h03, "R7 freeze quiet hold");
    step(8'h01, 0, 0, 0, 0, 1, 0, 0, 8'h01, "R6 master clear");
    step(8'h05, 0, 0, 0, 0, 0, 0, 0, 8'h05, "R6 freeze ended");
    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R2 wires low");

    step(8'h00, 8'h10, 0, 0, 0, 0, 0, 0, 8'h10, "R10 one source");
    step(8'h00, 8'h10, 0, 0, 0, 0, 0, 0, 8'h10, "R10 two sources");
    step(8'h00, 0, 8'h10, 0, 0, 0, 0, 0, 8'h10, "R10 one left");
    step(8'h00, 0, 8'h10, 0, 0, 0, 0, 0, 8'h00, "R10 none left");

    step(8'h20, 0, 0, 0, 0, 0, 0, 0, 8'h20, "R4 level wire");
    step(8'h20, 0, 0, 0, 8'h20, 0, 0, 0, 8'h00, "R4 ack level");
    step(8'h20, 0, 0, 0, 0, 0, 0, 1, 8'h20, "R4 re-request");
    step(8'h00, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 wire low");

    for (int k = 0; k < 8; k++)
      step(8'h00, 8'h40, 0, 0, 0, 0, 0, 0, 8'h40, "R10 count up");
    for (int k = 0; k < 6; k++)
      step(8'h00, 0, 8'h40, 0, 0, 0, 0, 0, 8'h40, "R10 saturated high");
    step(8'h00, 0, 8'h40, 0, 0, 0, 0, 0, 8'h00, "R10 reached zero");
    step(8'h00, 0, 8'h40, 0, 0, 0, 0, 0, 8'h00, "R10 saturated low");
    step(8'h00, 8'h40, 0, 0, 0, 0, 0, 0, 8'h40, "R10 one after floor");

    step(8'h00, 0, 0, 0, 0, 0, 1, 0, 8'h40, "R7 freeze level hold");
    step(8'h00, 8'h10, 0, 0, 0, 0, 0, 0, 8'h40, "R7 source event frozen");
    step(8'h00, 0, 0, 0, 0, 0, 0, 1, 8'h50, "R9 release");
    step(8'h00, 8'h80, 8'h80, 0, 0, 0, 0, 0, 8'h50, "R10 set and clear");
    step(8'h08, 0, 0, 0, 0, 0, 0, 0, 8'h58, "R11 line3 only");
    step(8'h08, 0, 0, 0, 0, 0, 0, 0, 8'h58, "R11 hold");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule